// File: doc/BRIEF.md
# Shared Memory Arbiter with Atomic Sequence Lock

This block sits in front of one shared memory module and takes requests from several processor ports. Each port offers a request with a valid/ready handshake that carries a read/write flag, an address, write data and an indivisibility flag. When no atomic sequence is running, the arbiter picks one valid port per cycle with a rotating pointer, so no port has a fixed advantage and none starves.

A request accepted with the indivisibility flag set starts an atomic sequence. From then on the arbiter serves only the port that started it and does not look at the valid signals of the other ports, even while that port is idle. The sequence ends with the first request from that port whose flag is clear. That last request is still served, and open arbitration resumes on the next cycle. A lone request with the flag clear is an ordinary access and never starts a lock. Accepted requests go to a synchronous RAM with a latency of one cycle. The served port then receives a one-cycle response pulse, and read data travels with it.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: After reset the arbiter is unlocked, its rotating pointer names port 0, no response is pending, and req_ready is all zero while no port is valid.
- R2: In open mode, req_ready is set for at most one port per cycle. That port is the first valid port found by searching upward from the pointer, wrapping from the highest port to port 0. After each accepted request the pointer moves to the port above the served one.
- R3: Once a request with req_atomic=1 from port p is accepted, only port p can receive req_ready in later cycles. The valid signals of all other ports are ignored, even while port p is not valid.
- R4: A request from the locking port with req_atomic=0 is served, and arbitration is open again in the following cycle.
- R5: A request accepted with req_atomic=0 while the arbiter is open does not lock it.
- R6: An accepted write (req_write=1) stores the port's write data at its address. An accepted read (req_write=0) returns the word most recently written to that address.
- R7: Exactly one cycle after a request is accepted, rsp_valid pulses for one cycle on the served port's bit only. For a read, rsp_rdata carries the read word in that cycle.
- R8: With all ports valid in every cycle, N consecutive grants serve each of the N ports exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_PORTS | Request offered, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| req_atomic | input | NUM_PORTS | Indivisibility flag, one bit per port |
| req_addr | input | NUM_PORTS*ADDR_W | Word address, port p in slice p |
| req_wdata | input | NUM_PORTS*DATA_W | Write data, port p in slice p |
| rsp_valid | output | NUM_PORTS | One-cycle response pulse on the served port |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |

## Verification
The grant is combinational, so req_ready is due in the same cycle the inputs are driven. The bench drives inputs on the falling edge and compares req_ready a few nanoseconds later against its own model of the pointer and lock. The response is due one rising edge after acceptance. Each accepted request is queued with a due cycle equal to the acceptance cycle plus one, and a monitor at the next falling edge checks that the pulse and data appear in exactly that cycle, not earlier and not later.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        ARB_OPEN   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_mode_e;

    // (a + b) modulo n, for pointer rotation
    function automatic int wrap_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/arb_grant.sv
module arb_grant
    import arb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [NUM_PORTS-1:0] valid,
    input  arb_mode_e            mode,
    input  logic [IDX_W-1:0]     owner,
    input  logic [IDX_W-1:0]     ptr,
    output logic [NUM_PORTS-1:0] grant,
    output logic [IDX_W-1:0]     gidx,
    output logic                 any
);

    logic [IDX_W-1:0] cand;

    always_comb begin
        gidx = '0;
        any  = 1'b0;
        cand = '0;
        if (mode == ARB_LOCKED) begin
            // only the sequence owner is looked at
            gidx = owner;
            any  = valid[owner];
        end else begin
            for (int k = 0; k < NUM_PORTS; k++) begin
                cand = IDX_W'(wrap_add(int'(ptr), k, NUM_PORTS));
                if (!any && valid[cand]) begin
                    any  = 1'b1;
                    gidx = cand;
                end
            end
        end
        grant = any ? (NUM_PORTS'(1) << gidx) : '0;
    end

endmodule

// File: rtl/arb_lock_state.sv
module arb_lock_state
    import arb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [IDX_W-1:0] gidx,
    input  logic             atomic,
    output arb_mode_e        mode,
    output logic [IDX_W-1:0] owner,
    output logic [IDX_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= ARB_OPEN;
            owner <= '0;
            ptr   <= '0;
        end else if (accept) begin
            mode  <= atomic ? ARB_LOCKED : ARB_OPEN;
            owner <= gidx;
            ptr   <= IDX_W'(wrap_add(int'(gidx), 1, NUM_PORTS));
        end
    end

endmodule

// File: rtl/arb_sram.sv
module arb_sram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/atomic_mem_arbiter.sv
module atomic_mem_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        req_valid,
    output logic [NUM_PORTS-1:0]        req_ready,
    input  logic [NUM_PORTS-1:0]        req_write,
    input  logic [NUM_PORTS-1:0]        req_atomic,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata
);

    typedef struct packed {
        logic              we;
        logic              atomic;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_cmd_t;

    arb_mode_e        mode;
    logic [IDX_W-1:0] owner;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] gidx;
    logic             accept;
    mem_cmd_t         cmd;

    arb_grant #(.NUM_PORTS(NUM_PORTS)) u_grant (
        .valid (req_valid),
        .mode  (mode),
        .owner (owner),
        .ptr   (ptr),
        .grant (req_ready),
        .gidx  (gidx),
        .any   (accept)
    );

    // mux the selected port's request fields
    always_comb begin
        cmd.we     = req_write[gidx];
        cmd.atomic = req_atomic[gidx];
        cmd.addr   = req_addr[gidx*ADDR_W +: ADDR_W];
        cmd.wdata  = req_wdata[gidx*DATA_W +: DATA_W];
    end

    arb_lock_state #(.NUM_PORTS(NUM_PORTS)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .gidx   (gidx),
        .atomic (cmd.atomic),
        .mode   (mode),
        .owner  (owner),
        .ptr    (ptr)
    );

    arb_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk   (clk),
        .en    (accept),
        .we    (cmd.we),
        .addr  (cmd.addr),
        .wdata (cmd.wdata),
        .rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
        end else begin
            rsp_valid <= req_ready;
        end
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready)); // R2

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0); // R2

    AST_LOCK_ENTER: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd.atomic) |=> (mode == ARB_LOCKED && owner == $past(gidx))); // R3

    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (mode == ARB_LOCKED) |-> ((req_ready & ~(NUM_PORTS'(1) << owner)) == '0)); // R3

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd.atomic) |=> (mode == ARB_OPEN)); // R4

    AST_RSP_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rsp_valid == $past(req_ready))); // R7

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (rsp_valid == '0)); // R7

endmodule

// File: tb/atomic_mem_arbiter_bench.sv
module atomic_mem_arbiter_bench;

    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_valid, req_ready, req_write, req_atomic, rsp_valid;
    logic [N*AW-1:0] req_addr;
    logic [N*DW-1:0] req_wdata;
    logic [DW-1:0] rsp_rdata;

    logic [AW-1:0] p_addr [N];
    logic [DW-1:0] p_data [N];

    always #10 clk = ~clk;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            req_addr[p*AW +: AW]  = p_addr[p];
            req_wdata[p*DW +: DW] = p_data[p];
        end
    end

    atomic_mem_arbiter #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u_atomic_mem_arbiter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_atomic(req_atomic),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          port;
        bit          is_read;
        logic [31:0] data;
    } exp_t;
    exp_t sb[$];

    // bench model
    bit          m_locked = 0;
    int          m_owner  = 0;
    int          m_ptr    = 0;
    logic [31:0] m_mem [256];
    logic [N-1:0] grant_hist;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_ports();
        req_valid  = '0;
        req_write  = '0;
        req_atomic = '0;
    endtask

    task automatic set_port(input int p, input bit wr, input bit at, input logic [7:0] a, input logic [31:0] d);
        req_valid[p]  = 1'b1;
        req_write[p]  = wr;
        req_atomic[p] = at;
        p_addr[p]     = a;
        p_data[p]     = d;
    endtask

    // driver: called just after a falling edge with inputs set
    task automatic step(input string tag);
        int   g;
        exp_t e;
        #2;
        g = -1;
        if (m_locked) begin
            if (req_valid[m_owner]) g = m_owner;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (g < 0 && req_valid[(m_ptr + k) % N]) g = (m_ptr + k) % N;
            end
        end
        check(req_ready == ((g < 0) ? 4'b0 : (4'b1 << g)), tag, 64'(req_ready),
              64'((g < 0) ? 4'b0 : (4'b1 << g)));
        if (g >= 0) begin
            grant_hist[g] = 1'b1;
            e.due     = cyc + 1;
            e.port    = g;
            e.is_read = !req_write[g];
            e.data    = m_mem[p_addr[g]];
            sb.push_back(e);
            if (req_write[g]) m_mem[p_addr[g]] = p_data[g];
            m_locked = req_atomic[g];
            m_owner  = g;
            m_ptr    = (g + 1) % N;
        end
        @(negedge clk);
    endtask

    // monitor: response due exactly one cycle after acceptance (R7)
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (rsp_valid != '0) begin
                if (sb.size() == 0 || sb[0].due != cyc) begin
                    check(1'b0, "R7 unexpected response", 64'(rsp_valid), 64'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_valid == (4'b1 << e.port), "R7 response port", 64'(rsp_valid),
                          64'(4'b1 << e.port));
                    if (e.is_read)
                        check(rsp_rdata === e.data, "R6 read data", 64'(rsp_rdata), 64'(e.data));
                end
            end else if (sb.size() != 0 && sb[0].due == cyc) begin
                check(1'b0, "R7 missing response", 64'(0), 64'(4'b1 << sb[0].port));
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        fork
            begin
                clear_ports();
                for (int p = 0; p < N; p++) begin
                    p_addr[p] = '0;
                    p_data[p] = '0;
                end
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                #2;
                // R1: idle after reset
                check(rsp_valid == '0, "R1 rsp after reset", 64'(rsp_valid), 64'(0));
                check(req_ready == '0, "R1 ready idle", 64'(req_ready), 64'(0));
                @(negedge clk);

                // R1 R2 R8: all ports valid, pointer starts at port 0
                grant_hist = '0;
                for (int p = 0; p < N; p++) set_port(p, 1'b1, 1'b0, 8'(10 + p), 32'hA000 + p);
                check(1'b1, "R1", 0, 0);
                for (int s = 0; s < N; s++) step("R2 round robin");
                check(grant_hist == 4'hF, "R8 each port once", 64'(grant_hist), 64'hF);
                grant_hist = '0;
                for (int s = 0; s < N; s++) step("R8 second round");
                check(grant_hist == 4'hF, "R8 each port once again", 64'(grant_hist), 64'hF);

                // R6: reads back through port 1
                clear_ports();
                for (int p = 0; p < N; p++) begin
                    set_port(1, 1'b0, 1'b0, 8'(10 + p), 0);
                    step("R6 read issue");
                end

                // R3: atomic sequence on port 2
                clear_ports();
                set_port(2, 1'b0, 1'b1, 8'd12, 0);
                step("R3 lock start");
                clear_ports();
                set_port(0, 1'b1, 1'b0, 8'd30, 32'hDEAD0000);
                set_port(1, 1'b1, 1'b0, 8'd31, 32'hDEAD0001);
                set_port(3, 1'b1, 1'b0, 8'd32, 32'hDEAD0003);
                step("R3 others ignored");
                step("R3 others ignored while owner idle");
                set_port(2, 1'b1, 1'b1, 8'd20, 32'h5555_0020);
                step("R3 owner continues");
                set_port(2, 1'b1, 1'b0, 8'd21, 32'h5555_0021);
                step("R4 final request served");
                req_valid[2] = 1'b0;
                step("R4 open again");
                step("R4 open rotation");
                step("R4 open rotation");
                check(sb.size() <= 1, "R4 backlog", 64'(sb.size()), 64'(1));

                // R5: lone access with flag clear does not lock
                clear_ports();
                set_port(1, 1'b0, 1'b0, 8'd20, 0);
                step("R5 lone access");
                clear_ports();
                set_port(0, 1'b0, 1'b0, 8'd21, 0);
                set_port(1, 1'b0, 1'b0, 8'd30, 0);
                step("R5 other port served after lone access");
                step("R5 remaining port");

                // R6: read back the locked and ignored writes
                clear_ports();
                for (int a = 30; a < 33; a++) begin
                    set_port(3, 1'b0, 1'b0, 8'(a), 0);
                    step("R6 read back");
                end
                clear_ports();
                repeat (3) @(negedge clk);
                check(sb.size() == 0, "R7 all responses seen", 64'(sb.size()), 64'(0));
            end
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 0);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule